// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block turns a reference clock, from a crystal or an external source, into a single-cycle clock-enable pulse. The pulse comes at sixteen times the serial bit rate, and a UART transmitter and receiver use it to pace their sampling. The reference is first divided by a prescaler that passes every cycle or every fourth cycle. A 16-bit divisor then divides it further. The resulting bit rate is reference / (prescale × divisor × 16).

A host programs the block through a narrow write port. One register holds the low divisor byte, one holds the high divisor byte, and one holds the mode byte. Only the top bit of the mode byte matters: it picks the slow prescaler. With a 14.7456 MHz reference and a divisor of 1, the bit rate is 921.6 kbaud with the prescaler off and 230.4 kbaud with it on. A divisor of 0x000C gives 76.8k or 19.2k. A divisor of 0x0900 gives 400 or 100 baud. A divisor of zero stops the pulses.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both divisor bytes are zero, the prescaler divides by 1, and `tick_16x` stays low.
- R2: The divisor is {high byte, low byte}. The low byte is written with `wr_sel`=0 and the high byte with `wr_sel`=1.
- R3: With the prescaler dividing by 1, a nonzero divisor D gives one pulse every D reference cycles.
- R4: A write with `wr_sel`=2 sets the prescaler from `wr_data[7]`: 0 selects divide-by-1 and 1 selects divide-by-4. The other seven bits of that byte have no effect.
- R5: While the divisor is zero, no pulse is produced.
- R6: A write to either divisor byte restarts both counters. No pulse appears in the cycle that follows the write, and the first pulse comes prescale × D cycles after the write edge.
- R7: A mode write that changes bit 7 restarts the prescaler phase and suppresses the next pulse. A mode write that keeps bit 7 unchanged leaves the pulse timing untouched.
- R8: Each pulse is one reference cycle wide whenever prescale × D is greater than 1.
- R9: A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 low byte, 1 high byte, 2 mode, 3 unused |
| wr_data | input | 8 | Write data |
| tick_16x | output | 1 | Single-cycle enable at 16 × the bit rate |

## Verification
On every cycle, the assertions check four things. The counters stay below their limits. No pulse follows a divisor write, a mode change or a zero divisor. A pulse never lasts two cycles when the total division is above one. The bench's reference model checks the exact pulse positions. Only its scenarios show that the pulse rate follows prescale × divisor for both byte halves, that the mode byte's low bits and select value 3 are ignored, and that rewriting the same mode bit keeps the phase.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int BYTE_W   = 8,
  parameter int SLOW_PRE = 4,
  parameter int MODE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick_16x
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int PRE_W = (SLOW_PRE > 1) ? $clog2(SLOW_PRE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOW_PRE - 1);

  logic [BYTE_W-1:0] div_lo, div_hi;
  logic              slow_q;
  logic [PRE_W-1:0]  pre_cnt;
  logic [DIV_W-1:0]  div_cnt;
  logic              tick_q;

  logic [DIV_W-1:0] divisor;
  logic wr_lo, wr_hi, reload, mode_chg, pre_last, div_last, div_on;

  assign divisor  = {div_hi, div_lo};
  assign div_on   = (divisor != '0);
  assign wr_lo    = wr_en && (wr_sel == 2'd0);
  assign wr_hi    = wr_en && (wr_sel == 2'd1);
  assign reload   = wr_lo || wr_hi;
  assign mode_chg = wr_en && (wr_sel == 2'd2) && (wr_data[MODE_BIT] != slow_q);
  assign pre_last = slow_q ? (pre_cnt == PRE_LAST) : 1'b1;
  assign div_last = (div_cnt == divisor - DIV_W'(1));
  assign tick_16x = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo <= '0;
      div_hi <= '0;
      slow_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel == 2'd0) div_lo <= wr_data;
      if (wr_sel == 2'd1) div_hi <= wr_data;
      if (wr_sel == 2'd2) slow_q <= wr_data[MODE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= !reload && !mode_chg && div_on && pre_last && div_last;
      if (reload) begin
        pre_cnt <= '0;
        div_cnt <= '0;
      end else if (mode_chg) begin
        pre_cnt <= '0;
      end else begin
        pre_cnt <= (!slow_q || pre_last) ? '0 : pre_cnt + PRE_W'(1);
        if (!div_on)
          div_cnt <= '0;
        else if (pre_last)
          div_cnt <= div_last ? '0 : div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int DIV_W    = 16,
  parameter int PRE_W    = 2,
  parameter int SLOW_PRE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             slow,
  input logic             reload,
  input logic             mode_chg,
  input logic [DIV_W-1:0] divisor,
  input logic [DIV_W-1:0] div_cnt,
  input logic [PRE_W-1:0] pre_cnt
);
  a_r5_zero_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |=> !tick);
  a_r6_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !tick);
  a_r7_mode_restart: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!tick && pre_cnt == '0));
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (slow || divisor != DIV_W'(1))) |=> !tick);
  a_r3_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != '0) |-> (div_cnt < divisor));
  a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slow ? (int'(pre_cnt) < SLOW_PRE) : (pre_cnt == '0));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W), .PRE_W(PRE_W), .SLOW_PRE(SLOW_PRE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_16x), .slow(slow_q), .reload(reload),
  .mode_chg(mode_chg), .divisor(divisor), .div_cnt(div_cnt), .pre_cnt(pre_cnt)
);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic tick_16x;
  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";

  baud_tick_gen dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
                       .wr_data(wr_data), .tick_16x(tick_16x));

  always #10 clk = ~clk;

  // behavioural reference: integers for phase, expected pulse
  int m_div = 0, m_pc = 0, m_dc = 0;
  bit m_slow = 0, m_tick = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_pc = 0; m_dc = 0; m_slow = 0; m_tick = 0;
    end else begin
      int p;
      bit rel, chg, pt;
      p   = m_slow ? 4 : 1;
      rel = wr_en && (wr_sel == 0 || wr_sel == 1);
      chg = wr_en && wr_sel == 2 && (wr_data[7] != m_slow);
      pt  = (m_pc == p - 1);
      m_tick = !rel && !chg && m_div != 0 && pt && (m_dc == m_div - 1);
      if (rel) begin m_pc = 0; m_dc = 0; end
      else if (chg) m_pc = 0;
      else begin
        m_pc = pt ? 0 : m_pc + 1;
        if (m_div == 0) m_dc = 0;
        else if (pt) m_dc = (m_dc == m_div - 1) ? 0 : m_dc + 1;
      end
      if (wr_en && wr_sel == 0) m_div = (m_div & 32'hFF00) | wr_data;
      if (wr_en && wr_sel == 1) m_div = (m_div & 32'h00FF) | (int'(wr_data) << 8);
      if (wr_en && wr_sel == 2) m_slow = wr_data[7];
    end
  end

  always @(negedge clk) begin
    cyc++;
    checks++;
    if (tick_16x !== m_tick) begin
      failures++;
      if (failures < 20)
        $display("FAIL %s cycle %0d tick actual=%0b expected=%0b", tag, cyc, tick_16x, m_tick);
    end
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
  endtask

  task automatic count(input string t, input int n, input int exp);
    int got = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick_16x) got++;
    end
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s pulse count actual=%0d expected=%0d", t, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; count("R1 reset idle", 50, 0);
    tag = "R3"; wr(2'd0, 8'd1); count("R3 D=1 div1", 20, 20);
    wr(2'd0, 8'd12); tag = "R6"; count("R6 R3 D=12 div1", 120, 10);
    tag = "R4"; wr(2'd2, 8'h80); wr(2'd0, 8'd12); count("R4 D=12 div4", 480, 10);
    wr(2'd2, 8'h7F); wr(2'd0, 8'd12); count("R4 low mode bits ignored", 120, 10);
    tag = "R2"; wr(2'd2, 8'h80); wr(2'd1, 8'h09); wr(2'd0, 8'h00);
    count("R2 D=0x0900 div4", 18432, 2);
    wr(2'd1, 8'h00); wr(2'd0, 8'd5);
    tag = "R9"; wr(2'd3, 8'hFF); count("R9 unused select", 199, 10);
    tag = "R7"; wr(2'd2, 8'h80); count("R7 same mode bit keeps phase", 199, 10);
    wr(2'd0, 8'd3); repeat (5) @(negedge clk);
    wr(2'd2, 8'h00); repeat (40) @(negedge clk);
    tag = "R8"; wr(2'd0, 8'd2); count("R8 D=2 div1", 40, 20);
    tag = "R5"; wr(2'd0, 8'd0); count("R5 zero divisor", 100, 0);
    tag = "R1"; rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    wr(2'd0, 8'd4); count("R1 reset restores div1", 40, 10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule